// File: doc/BRIEF.md
# Deglitched Fault Gate-Drive Controller

This block sits between a fast over-current (or similar) comparator and the enable path of an external power switch. It takes the comparator's raw digital decision and a switch-enable request, and it produces the one bit that commands the gate driver. The comparator signal is cleaned by an asymmetric filter: the time a new fault must persist is set at run time through an input, while the time a clearing fault must persist is a fixed design parameter. Once a fault passes the filter, the drive bit is pulled low on that same clock edge, whatever the enable request says.

After a fault clears, a recovery timer keeps the switch off for a programmable number of cycles. A fault that comes back while this timer runs cancels it, and the count starts over from the next clearing. A mode pin selects latched behaviour. In that mode a fault stays in force until the enable request has been dropped and the filtered fault has also cleared. The recovery time then runs from whichever of those two came last.

Top module: `fault_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `drive_o` is 0. Reset clears the filter to "no fault" and makes the recovery timer idle, so with `cmp_raw_i`=0 and `enable_i`=1 held across the release, `drive_o` is 1 after the first rising edge that follows the release.
- R2: With no filtered fault, no held latched fault and an idle timer, `drive_o` equals the value `enable_i` had at the previous rising clock edge.
- R3: A fault is accepted only after `cmp_raw_i` has been sampled high on max(`rise_dly_i`,1) consecutive edges. A shorter high pulse has no effect on `drive_o`, and any low sample restarts the count.
- R4: A filtered fault clears only after `cmp_raw_i` has been sampled low on FALL_DLY (default 3) consecutive edges. A high sample in between restarts that count.
- R5: On the edge where the filter accepts a fault, `drive_o` becomes 0, whatever the value of `enable_i`, and it stays 0 while the filtered fault lasts.
- R6: With `latch_mode_i`=0, if the filtered fault clears at edge E, `drive_o` is 0 up to edge E+`rec_len_i`-1 and follows `enable_i` again from edge E+`rec_len_i` onward. A `rec_len_i` of 0 releases at E.
- R7: A filtered fault accepted while the recovery timer is running cancels the timer. The full `rec_len_i` period is counted again from the next clearing.
- R8: With `latch_mode_i`=1, an accepted fault is held, and `drive_o` stays 0, until an edge at which `enable_i` is 0 and the filtered fault is clear. That edge starts the recovery time, with the same timing as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw comparator decision, 1 = fault level |
| enable_i | input | 1 | Switch-on request |
| latch_mode_i | input | 1 | 0 = self-clearing faults, 1 = latched faults |
| rise_dly_i | input | RISE_W (4) | Consecutive high samples needed to accept a fault (0 acts as 1) |
| rec_len_i | input | REC_W (4) | Recovery hold time in cycles |
| drive_o | output | 1 | Gate-drive command, 1 = switch on |

## Verification
The hardest cases to reach from the ports are the timer restart and the latched release. For the restart, a second fault must pass the rising filter while the recovery count is partway down. The bench builds this with an exact sequence of raw pulses and then measures the release edge: it must fall a full recovery period after the second clearing and not after the first. For the latched case, the enable drop must coincide with a filtered fault that is already clear, or must arrive during the falling filter window. The bench covers both orders. Filter acceptance is swept over every short rise delay against every pulse width up to one beyond it.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    // registered state of the top-level drive logic
    typedef struct packed {
        logic hold;    // fault still in force (filtered or latched)
        logic drive;   // gate-drive command
    } fgc_drive_s;

    // a programmed delay of zero behaves as one cycle
    function automatic int unsigned fgc_min1(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/fgc_deglitch.sv
module fgc_deglitch #(
    parameter int RISE_W   = 4,
    parameter int FALL_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic [RISE_W-1:0] rise_dly_i,
    output logic              filt_d_o,
    output logic              filt_q_o
);
    localparam int FALL_W = $clog2(FALL_DLY + 1);
    localparam int CW     = (RISE_W > FALL_W) ? RISE_W : FALL_W;

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_s;

    flt_s          st_d, st_q;
    logic [CW-1:0] tgt;
    logic [CW:0]   inc;

    always_comb begin
        st_d = st_q;
        tgt  = st_q.filt ? CW'(FALL_DLY) : CW'(rise_dly_i);
        if (tgt == '0) tgt = CW'(1);
        inc  = {1'b0, st_q.cnt} + (CW+1)'(1);
        if (raw_i == st_q.filt) begin
            st_d.cnt = '0;
        end else if (inc >= {1'b0, tgt}) begin
            st_d.filt = ~st_q.filt;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = inc[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_d_o = st_d.filt;
    assign filt_q_o = st_q.filt;

    // R3: a fault is only accepted on a high sample
    a_r3_rise_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt && !$past(st_q.filt)) |-> $past(raw_i));

    // R4: a fault only clears on a low sample
    a_r4_fall_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.filt && $past(st_q.filt)) |-> !$past(raw_i));

endmodule

// File: rtl/fgc_rec_timer.sv
module fgc_rec_timer #(
    parameter int REC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cancel_i,
    input  logic [REC_W-1:0] len_i,
    output logic [REC_W-1:0] cnt_d_o,
    output logic [REC_W-1:0] cnt_q_o
);
    logic [REC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cancel_i)           cnt_d = '0;
        else if (start_i)       cnt_d = len_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - REC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_d_o = cnt_d;
    assign cnt_q_o = cnt_q;

    // R6: a running count never jumps up without a new start
    a_r6_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(start_i) && !$past(cancel_i))
            |-> (cnt_q == $past(cnt_q) - REC_W'(1)));

endmodule

// File: rtl/fault_gate_ctrl.sv
module fault_gate_ctrl #(
    parameter int RISE_W   = 4,
    parameter int FALL_DLY = 3,
    parameter int REC_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw_i,
    input  logic              enable_i,
    input  logic              latch_mode_i,
    input  logic [RISE_W-1:0] rise_dly_i,
    input  logic [REC_W-1:0]  rec_len_i,
    output logic              drive_o
);
    import fgc_pkg::*;

    logic             filt_d, filt_q;
    logic             clear_evt;
    logic [REC_W-1:0] rec_d, rec_q;
    fgc_drive_s       st_d, st_q;

    fgc_deglitch #(.RISE_W(RISE_W), .FALL_DLY(FALL_DLY)) u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (cmp_raw_i),
        .rise_dly_i (rise_dly_i),
        .filt_d_o   (filt_d),
        .filt_q_o   (filt_q)
    );

    fgc_rec_timer #(.REC_W(REC_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (clear_evt),
        .cancel_i (filt_d),
        .len_i    (rec_len_i),
        .cnt_d_o  (rec_d),
        .cnt_q_o  (rec_q)
    );

    always_comb begin
        st_d = st_q;
        if (filt_d)
            st_d.hold = 1'b1;
        else if (st_q.hold && !(latch_mode_i && enable_i))
            st_d.hold = 1'b0;
        clear_evt  = st_q.hold && !st_d.hold;
        st_d.drive = enable_i && !filt_d && !st_d.hold && (rec_d == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_o = st_q.drive;

    // R5: the switch is off whenever a filtered fault stands
    a_r5_fault_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        filt_q |-> !drive_o);

    // R6: the switch is off while recovery counts
    a_r6_recovery_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q != '0) |-> !drive_o);

    // R7: a standing fault leaves the timer idle
    a_r7_fault_cancels_timer: assert property (@(posedge clk) disable iff (!rst_n)
        filt_q |-> (rec_q == '0));

    // R8: a held latched fault keeps the switch off
    a_r8_latch_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode_i && st_q.hold) |-> !drive_o);

    // R2: the switch never turns on without a prior request
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> $past(enable_i));

endmodule

// File: tb/fault_gate_ctrl_bench.sv
`timescale 1ns/1ps
module fault_gate_ctrl_bench;
    localparam int RISE_W = 4;
    localparam int FALL_DLY = 3;
    localparam int REC_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_raw = 1'b0;
    logic enable = 1'b0;
    logic latch_mode = 1'b0;
    logic [RISE_W-1:0] rise_dly = 4'd1;
    logic [REC_W-1:0]  rec_len = 4'd2;
    logic drive;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fault_gate_ctrl #(.RISE_W(RISE_W), .FALL_DLY(FALL_DLY), .REC_W(REC_W)) u_fault_gate_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_raw_i    (cmp_raw),
        .enable_i     (enable),
        .latch_mode_i (latch_mode),
        .rise_dly_i   (rise_dly),
        .rec_len_i    (rec_len),
        .drive_o      (drive)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: drive_o=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // settle to idle with the switch requested on
    task automatic settle();
        cmp_raw = 1'b0;
        enable  = 1'b1;
        tick(24);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        enable = 1'b1;
        tick(2);
        chk("R1 in reset", drive, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 first edge after release", drive, 1'b1);

        // R2: follow enable with one register stage
        for (int p = 0; p < 8; p++) begin
            enable = p[0] ^ p[2];
            tick(1);
            chk("R2 follow enable", drive, p[0] ^ p[2]);
        end

        // R3/R5/R6: sweep rise delay against pulse width, rec_len = 2
        latch_mode = 1'b0;
        rec_len = 4'd2;
        for (int r = 1; r <= 4; r++) begin
            for (int w = 1; w <= 5; w++) begin
                rise_dly = RISE_W'(r);
                settle();
                cmp_raw = 1'b1;
                for (int k = 1; k <= w; k++) begin
                    tick(1);
                    chk("R3 R5 rise filter", drive, (k >= r) ? 1'b0 : 1'b1);
                end
                cmp_raw = 1'b0;
                for (int k = 1; k <= 6; k++) begin
                    tick(1);
                    if (w >= r)
                        chk("R6 recovery release", drive, (k >= FALL_DLY + 2) ? 1'b1 : 1'b0);
                    else
                        chk("R3 short pulse ignored", drive, 1'b1);
                end
            end
        end

        // R3: rise_dly 0 acts as 1
        rise_dly = 4'd0;
        settle();
        cmp_raw = 1'b1;
        tick(1);
        chk("R3 zero delay as one", drive, 1'b0);

        // R5: enable cannot override a standing fault
        rise_dly = 4'd1;
        rec_len = 4'd0;
        settle();
        cmp_raw = 1'b1;
        tick(1);
        enable = 1'b0;
        tick(2);
        enable = 1'b1;
        tick(2);
        chk("R5 fault over enable", drive, 1'b0);
        // R6: rec_len 0 releases on the clearing edge
        cmp_raw = 1'b0;
        tick(FALL_DLY - 1);
        chk("R6 before clear", drive, 1'b0);
        tick(1);
        chk("R6 zero recovery", drive, 1'b1);

        // R4: falling bounce restarts the fixed count
        rec_len = 4'd2;
        settle();
        cmp_raw = 1'b1;
        tick(1);
        cmp_raw = 1'b0;
        tick(FALL_DLY - 1);
        cmp_raw = 1'b1;
        tick(1);
        cmp_raw = 1'b0;
        for (int k = 1; k <= FALL_DLY + 2; k++) begin
            tick(1);
            chk("R4 fall bounce restart", drive, (k >= FALL_DLY + 2) ? 1'b1 : 1'b0);
        end

        // R7: refault during recovery restarts the full period
        rec_len = 4'd6;
        settle();
        cmp_raw = 1'b1;
        tick(1);
        cmp_raw = 1'b0;
        tick(FALL_DLY + 3);
        chk("R7 mid recovery", drive, 1'b0);
        cmp_raw = 1'b1;
        tick(1);
        chk("R7 refault low", drive, 1'b0);
        cmp_raw = 1'b0;
        for (int k = 1; k <= FALL_DLY + 6; k++) begin
            tick(1);
            chk("R7 full restart", drive, (k >= FALL_DLY + 6) ? 1'b1 : 1'b0);
        end

        // R8: latched, fault clears first, enable dropped later
        latch_mode = 1'b1;
        rec_len = 4'd3;
        settle();
        cmp_raw = 1'b1;
        tick(1);
        cmp_raw = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            tick(1);
            chk("R8 latched hold", drive, 1'b0);
        end
        enable = 1'b0;
        tick(1);
        enable = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick(1);
            chk("R8 release after enable low", drive, (k >= 3) ? 1'b1 : 1'b0);
        end

        // R8: latched, enable dropped first, fault clears later
        settle();
        cmp_raw = 1'b1;
        tick(1);
        enable = 1'b0;
        tick(2);
        cmp_raw = 1'b0;
        tick(FALL_DLY);
        enable = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick(1);
            chk("R8 release from fault clear", drive, (k >= 3) ? 1'b1 : 1'b0);
        end

        // R8: enable pulsed low while fault still stands does not release
        settle();
        cmp_raw = 1'b1;
        tick(1);
        enable = 1'b0;
        tick(1);
        enable = 1'b1;
        cmp_raw = 1'b0;
        tick(FALL_DLY + 8);
        chk("R8 early enable pulse ignored", drive, 1'b0);

        // R1: reset in the middle of a fault
        cmp_raw = 1'b1;
        tick(2);
        rst_n = 1'b0;
        cmp_raw = 1'b0;
        tick(1);
        chk("R1 reset mid fault", drive, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 clean after reset", drive, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule